// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the configuration register file of a data converter. Software reaches it over a serial port made of a chip select, a serial clock, a data input and a data output with its own enable. The data output and its enable can be joined to the input pin outside the block for a single-data-wire (3-wire) port, or left separate for a 4-wire port. The serial pins are synchronised into the block clock, so the serial clock must run well below the block clock.

Each transaction begins with a 16-bit instruction word, followed by one or more data bytes. The programmable registers are double-buffered. A serial write lands in a shadow copy, and that copy is the one read back. The outputs that steer the converter follow a live copy, which is loaded from the shadow copy in one step when software sets the commit bit. The port-configuration byte is different: it takes effect as soon as it is written. Its two control bits are each stored in two mirrored positions, so the byte decodes the same way whichever bit order carried it.

The live state reaches the rest of the chip only as three outputs: the active shift order, a two-bit power state, and the clock stabiliser enable.

Top module: `cfg_serial_regbank`

## Requirements
- R1: After rst_n, address 0x00 reads 0x18, address 0x08 reads 0x00 and address 0x09 reads 0x01. The outputs show MSB-first order (lsb_first=0), the normal power state (pwr_mode=0) and dcs_en=1.
- R2: The instruction word carries a read flag in bit 15 (1 = read), a count field in bits 14:13 and an address in bits 12:0.
  - The count field is 00 for one byte, 01 for two, 10 for three and 11 for as many bytes as the chip select stays low. Bits beyond the counted bytes are ignored.
  - Data is sampled on the rising serial clock edge.
  - From byte to byte, the address counts down in MSB-first order and up in LSB-first order.
- R3: A write to 0x08 or 0x09 changes the value read back at once, but leaves pwr_mode and dcs_en unchanged until a commit.
- R4: Writing 1 to bit 0 of 0xFF copies every shadow register into the live copy in one step. The commit bit then clears itself, so 0xFF reads 0x00.
- R5: Writing 0x00 with bit 6 or bit 1 set selects LSB-first order for the instruction word and all data bits. Clearing both bits selects MSB-first order. The readback sets or clears bits 6 and 1 together, and always has bits 4 and 3 set.
- R6: Writing 0x00 with bit 5 or bit 2 set restores the reset values of every register, in both the shadow and live copies, including MSB-first order. Address 0x00 then reads 0x18.
- R7: Address 0x01 returns the CHIP_ID parameter (0xA5 by default). Address 0x02 returns the SPEED_GRADE parameter in bits 4:3 (10 by default, giving 0x10). Writes to 0x01 and 0x02 are ignored.
- R8: Bits 2:0 of 0x08 select the internal power state: 001 gives full power-down (pwr_mode=1), 010 gives standby (pwr_mode=2), and any other code gives normal (pwr_mode=0). Only bits 5 and 2:0 of 0x08 and bit 0 of 0x09 are stored. All other bits read 0.
- R9: While pdwn_pin is high, it overrides bits 2:0 of 0x08. The pin then gives full power-down if live bit 5 of 0x08 is 0, and standby if that bit is 1.
- R10: dcs_en follows live bit 0 of 0x09.
- R11: A read of any address other than 0x00, 0x01, 0x02, 0x08, 0x09 and 0xFF returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| pdwn_pin | input | 1 | External power-down request |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for sdo |
| lsb_first | output | 1 | Active shift order, 1 = LSB first |
| pwr_mode | output | 2 | 0 normal, 1 full power-down, 2 standby |
| dcs_en | output | 1 | Clock duty-cycle stabiliser enable |

## Verification
The commit of the live copy and a change on the external power-down pin can reach the power state in the same few clock cycles. A new override sense in bit 5 of 0x08 is committed while the pin rises.

To provoke this, the bench raises pdwn_pin together with the last serial clock edge of the commit write. It then requires pwr_mode to show standby, which is only correct if the pin is read with the newly committed sense rather than the old one. After the pin is released, it requires the committed full power-down field to show through.

// File: rtl/cfg_serial_regbank.sv
module cfg_serial_regbank #(
  parameter logic [7:0] CHIP_ID     = 8'hA5,
  parameter logic [1:0] SPEED_GRADE = 2'b10,
  parameter int         ADDR_W      = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csb_n,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       pdwn_pin,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       lsb_first,
  output logic [1:0] pwr_mode,
  output logic       dcs_en
);
  localparam int IW = 3 + ADDR_W;
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_GRD  = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(8'h09);
  localparam logic [ADDR_W-1:0] A_XFER = ADDR_W'(8'hFF);
  localparam logic [7:0] MODE_MASK = 8'h27;
  localparam logic [7:0] CLK_MASK  = 8'h01;
  localparam logic [1:0] PM_NORM = 2'd0, PM_FULL = 2'd1, PM_STBY = 2'd2;

  logic [2:0] sclk_s;
  logic [1:0] csb_s, sdi_s;
  logic [IW-1:0] shreg;
  logic [3:0] cnt;
  logic in_instr, done, rw;
  logic [1:0] wcnt, nbytes;
  logic [ADDR_W-1:0] addr;
  logic [7:0] rd_byte;
  logic lsb_q, xfer_q;
  logic [7:0] modes_m, clk_m, modes_s, clk_sr;

  function automatic logic [IW-1:0] rev_w(input logic [IW-1:0] v);
    for (int i = 0; i < IW; i++) rev_w[i] = v[IW-1-i];
  endfunction
  function automatic logic [7:0] rev_b(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev_b[i] = v[7-i];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0; csb_s <= 2'b11; sdi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      csb_s  <= {csb_s[0], csb_n};
      sdi_s  <= {sdi_s[0], sdi};
    end

  wire active = !csb_s[1];
  wire rise   = active && sclk_s[1] && !sclk_s[2];
  wire [IW-1:0] sh_next = {shreg[IW-2:0], sdi_s[1]};
  wire [IW-1:0] instr   = lsb_q ? rev_w(sh_next) : sh_next;
  wire [7:0] dbyte      = lsb_q ? rev_b(sh_next[7:0]) : sh_next[7:0];
  wire byte_end = rise && !in_instr && !done && cnt == 4'd7;
  wire wr_en    = byte_end && !rw;
  wire srst     = wr_en && addr == A_PORT && (dbyte[5] || dbyte[2]);
  wire [ADDR_W-1:0] addr_nx = lsb_q ? addr + 1'b1 : addr - 1'b1;

  function automatic logic [7:0] rd_mux(input logic [ADDR_W-1:0] a);
    case (a)
      A_PORT:  rd_mux = {1'b0, lsb_q, 1'b0, 2'b11, 1'b0, lsb_q, 1'b0};
      A_ID:    rd_mux = CHIP_ID;
      A_GRD:   rd_mux = {3'b000, SPEED_GRADE, 3'b000};
      A_MODE:  rd_mux = modes_m;
      A_CLK:   rd_mux = clk_m;
      A_XFER:  rd_mux = {7'd0, xfer_q};
      default: rd_mux = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; cnt <= '0; in_instr <= 1'b1; done <= 1'b0; rw <= 1'b0;
      wcnt <= '0; nbytes <= '0; addr <= '0; rd_byte <= '0;
    end else if (!active) begin
      cnt <= '0; in_instr <= 1'b1; done <= 1'b0; nbytes <= '0;
    end else if (rise && in_instr) begin
      shreg <= sh_next;
      cnt   <= cnt + 1'b1;
      if (cnt == 4'(IW - 1)) begin
        in_instr <= 1'b0;
        cnt      <= '0;
        rw       <= instr[IW-1];
        wcnt     <= instr[IW-2:IW-3];
        addr     <= instr[ADDR_W-1:0];
        rd_byte  <= rd_mux(instr[ADDR_W-1:0]);
      end
    end else if (rise && !done) begin
      shreg <= sh_next;
      cnt   <= cnt + 1'b1;
      if (cnt == 4'd7) begin
        cnt     <= '0;
        nbytes  <= nbytes + 1'b1;
        addr    <= addr_nx;
        rd_byte <= rd_mux(addr_nx);
        if (wcnt != 2'b11 && nbytes == wcnt) done <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lsb_q <= 1'b0; xfer_q <= 1'b0;
      modes_m <= 8'h00; clk_m <= 8'h01; modes_s <= 8'h00; clk_sr <= 8'h01;
    end else if (srst) begin
      lsb_q <= 1'b0; xfer_q <= 1'b0;
      modes_m <= 8'h00; clk_m <= 8'h01; modes_s <= 8'h00; clk_sr <= 8'h01;
    end else begin
      if (xfer_q) begin
        modes_s <= modes_m;
        clk_sr  <= clk_m;
        xfer_q  <= 1'b0;
      end
      if (wr_en)
        case (addr)
          A_PORT: lsb_q   <= dbyte[6] || dbyte[1];
          A_MODE: modes_m <= dbyte & MODE_MASK;
          A_CLK:  clk_m   <= dbyte & CLK_MASK;
          A_XFER: xfer_q  <= dbyte[0];
          default: ;
        endcase
    end

  wire [2:0] bsel = lsb_q ? cnt[2:0] : 3'd7 - cnt[2:0];
  assign sdo_oe    = active && !in_instr && rw && !done;
  assign sdo       = sdo_oe && rd_byte[bsel];
  assign lsb_first = lsb_q;
  assign dcs_en    = clk_sr[0];

  always_comb
    if (pdwn_pin)
      pwr_mode = modes_s[5] ? PM_STBY : PM_FULL;
    else
      case (modes_s[2:0])
        3'b001:  pwr_mode = PM_FULL;
        3'b010:  pwr_mode = PM_STBY;
        default: pwr_mode = PM_NORM;
      endcase

  AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |=> !xfer_q); // R4
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_q && !srst) |=> $stable({modes_s, clk_sr})); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((modes_m & ~MODE_MASK) == 8'h00) && ((clk_sr & ~CLK_MASK) == 8'h00)); // R8
  AST_PIN_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pdwn_pin |-> pwr_mode != PM_NORM); // R9
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!lsb_first && modes_s == 8'h00 && dcs_en)); // R6
endmodule

// File: tb/tb_cfg_serial_regbank.sv
module tb_cfg_serial_regbank;
  logic clk = 1'b0, rst_n = 1'b0, csb_n = 1'b1, sclk = 1'b0, sdi = 1'b0, pdwn_pin = 1'b0;
  logic sdo, sdo_oe, lsb_first, dcs_en;
  logic [1:0] pwr_mode;
  int checks = 0, fails = 0;
  bit b_lsb = 1'b0;
  logic [7:0] wd [0:3];
  logic [7:0] rq [0:3];

  always #5 clk = ~clk;

  cfg_serial_regbank dut (.clk(clk), .rst_n(rst_n), .csb_n(csb_n), .sclk(sclk), .sdi(sdi),
    .pdwn_pin(pdwn_pin), .sdo(sdo), .sdo_oe(sdo_oe), .lsb_first(lsb_first),
    .pwr_mode(pwr_mode), .dcs_en(dcs_en));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    sdi = b; #100; r = sdo; sclk = 1'b1; #100; sclk = 1'b0;
  endtask

  task automatic txn(input bit rd, input logic [1:0] wc, input logic [12:0] a, input int nb);
    logic [15:0] iw;
    logic r;
    iw = {rd, wc, a};
    csb_n = 1'b0; #100;
    for (int i = 0; i < 16; i++) sbit(iw[b_lsb ? i : 15 - i], r);
    for (int k = 0; k < nb; k++)
      for (int i = 0; i < 8; i++) begin
        sbit(wd[k][b_lsb ? i : 7 - i], r);
        rq[k][b_lsb ? i : 7 - i] = r;
      end
    #100; csb_n = 1'b1; #300;
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    wd[0] = d; txn(1'b0, 2'b00, a, 1);
  endtask
  task automatic rd1(input logic [12:0] a, input logic [7:0] exp, input string tag);
    wd[0] = 8'h00; txn(1'b1, 2'b00, a, 1); chk(rq[0], exp, tag);
  endtask

  task automatic t_reset;
    chk({7'd0, lsb_first}, 8'd0, "R1 lsb_first");
    chk({6'd0, pwr_mode}, 8'd0, "R1 pwr_mode");
    chk({7'd0, dcs_en}, 8'd1, "R1 dcs_en");
    rd1(13'h000, 8'h18, "R1 port cfg");
    rd1(13'h008, 8'h00, "R1 modes");
    rd1(13'h009, 8'h01, "R1 clock");
  endtask

  task automatic t_readonly;
    wr1(13'h001, 8'h00);
    wr1(13'h002, 8'hFF);
    rd1(13'h001, 8'hA5, "R7 chip id");
    rd1(13'h002, 8'h10, "R7 grade");
    rd1(13'h005, 8'h00, "R11 unmapped 0x05");
    rd1(13'h123, 8'h00, "R11 unmapped 0x123");
  endtask

  task automatic t_shadow_commit;
    wr1(13'h009, 8'h00);
    wr1(13'h008, 8'h01);
    rd1(13'h009, 8'h00, "R3 clock shadow");
    rd1(13'h008, 8'h01, "R3 modes shadow");
    chk({7'd0, dcs_en}, 8'd1, "R3 dcs_en held");
    chk({6'd0, pwr_mode}, 8'd0, "R3 pwr_mode held");
    wr1(13'h0FF, 8'h01);
    chk({7'd0, dcs_en}, 8'd0, "R10 dcs_en committed");
    chk({6'd0, pwr_mode}, 8'd1, "R4 committed full power-down");
    rd1(13'h0FF, 8'h00, "R4 commit bit self-clears");
  endtask

  task automatic t_pd_codes;
    logic [2:0] code [0:2];
    logic [1:0] expm [0:2];
    code[0] = 3'b010; expm[0] = 2'd2;
    code[1] = 3'b011; expm[1] = 2'd0;
    code[2] = 3'b111; expm[2] = 2'd0;
    for (int i = 0; i < 3; i++) begin
      wr1(13'h008, {5'b11010, code[i]});
      wr1(13'h0FF, 8'h01);
      chk({6'd0, pwr_mode}, {6'd0, expm[i]}, "R8 power code");
      rd1(13'h008, {5'd0, code[i]}, "R8 reserved bits read 0");
    end
    wr1(13'h009, 8'hFF);
    rd1(13'h009, 8'h01, "R8 clock reserved bits");
  endtask

  task automatic t_stream;
    wd[0] = 8'h01; wd[1] = 8'h02;
    txn(1'b0, 2'b01, 13'h009, 2);
    wd[0] = 8'h00; wd[1] = 8'h00;
    txn(1'b1, 2'b01, 13'h009, 2);
    chk(rq[0], 8'h01, "R2 msb stream byte0 (0x09)");
    chk(rq[1], 8'h02, "R2 msb stream byte1 (0x08 decrement)");
    wd[0] = 8'h00; wd[1] = 8'h05;
    txn(1'b0, 2'b00, 13'h009, 2);
    rd1(13'h009, 8'h00, "R2 counted byte written");
    rd1(13'h008, 8'h02, "R2 byte past count ignored");
  endtask

  task automatic t_pin_commit;
    wr1(13'h008, 8'h00);
    wr1(13'h0FF, 8'h01);
    pdwn_pin = 1'b1; #100;
    chk({6'd0, pwr_mode}, 8'd1, "R9 pin gives full power-down");
    pdwn_pin = 1'b0; #100;
    chk({6'd0, pwr_mode}, 8'd0, "R9 pin released");
    wr1(13'h008, 8'h21);
    begin : race
      logic r;
      logic [15:0] iw;
      iw = {1'b0, 2'b00, 13'h0FF};
      csb_n = 1'b0; #100;
      for (int i = 0; i < 16; i++) sbit(iw[15 - i], r);
      for (int i = 0; i < 7; i++) sbit(i == 7 ? 1'b1 : 1'b0, r);
      sdi = 1'b1; #100; sclk = 1'b1; pdwn_pin = 1'b1; #100; sclk = 1'b0;
      #100; csb_n = 1'b1; #300;
    end
    chk({6'd0, pwr_mode}, 8'd2, "R9 pin with committed standby sense");
    pdwn_pin = 1'b0; #100;
    chk({6'd0, pwr_mode}, 8'd1, "R9 field shows after release");
  endtask

  task automatic t_lsb;
    wr1(13'h000, 8'h40);
    b_lsb = 1'b1;
    chk({7'd0, lsb_first}, 8'd1, "R5 lsb_first set");
    wd[0] = 8'h00; wd[1] = 8'h00; wd[2] = 8'h00;
    txn(1'b1, 2'b10, 13'h000, 3);
    chk(rq[0], 8'h5A, "R5 mirrored readback");
    chk(rq[1], 8'hA5, "R2 lsb stream increments to 0x01");
    chk(rq[2], 8'h10, "R2 lsb stream increments to 0x02");
    wr1(13'h009, 8'h01);
    rd1(13'h009, 8'h01, "R5 lsb-first write");
    wr1(13'h000, 8'h00);
    b_lsb = 1'b0;
    chk({7'd0, lsb_first}, 8'd0, "R5 back to msb first");
    rd1(13'h000, 8'h18, "R5 readback msb");
  endtask

  task automatic t_srst;
    wr1(13'h000, 8'h02);
    b_lsb = 1'b1;
    wr1(13'h008, 8'h02);
    wr1(13'h009, 8'h00);
    wr1(13'h000, 8'h24);
    b_lsb = 1'b0;
    chk({7'd0, lsb_first}, 8'd0, "R6 order default");
    chk({6'd0, pwr_mode}, 8'd0, "R6 live modes default");
    chk({7'd0, dcs_en}, 8'd1, "R6 live clock default");
    rd1(13'h000, 8'h18, "R6 port cfg default");
    rd1(13'h008, 8'h00, "R6 modes shadow default");
    rd1(13'h009, 8'h01, "R6 clock shadow default");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #53; rst_n = 1'b1; #100;
    t_reset;
    t_readonly;
    t_shadow_commit;
    t_pd_codes;
    t_stream;
    t_pin_commit;
    t_lsb;
    t_srst;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule